// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Half-Word Masked Output Writes

This block controls a set of general-purpose pin banks behind a simple register bus. Every bank has up to 32 pins, a direction word, an output-enable word and a read-only word that reflects the synchronized pin levels. Output levels are never changed by read-modify-write. Software writes one 32-bit word that carries a 16-bit per-pin write mask in its upper half and 16 data bits in its lower half. One such word exists for pins 0 to 15 of a bank and another for pins 16 to 31. Pins whose mask bit is clear take the new data. Pins whose mask bit is set keep their level.

The number of banks and the pin count of each bank are parameters. A bank may be narrower than 32 pins. Its unused upper bits are not stored and read as zero. A pin drives its pad only when its direction bit and its output-enable bit are both set. Two pins of bank 0 carry a direction lock: once they have been made outputs, they cannot be turned back into inputs. Register reads return data on the clock after the read strobe.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every output level, direction bit and output-enable bit is 0, so `pin_out` and `pin_oe` are all zero and the direction and output-enable words read 0.
- R2: A write to address 0x000 + 8*b sets pin k (0..15) of bank b to data bit k of `bus_wdata` for every k whose mask bit (bit 16+k) is 0. The change is visible on `pin_out` one clock after the write.
- R3: In a masked write, a pin whose mask bit is 1 keeps its previous output level.
- R4: A write to address 0x004 + 8*b applies the same mask/data rule to pins 16..31 of bank b. Data bit k and mask bit 16+k govern pin 16+k.
- R5: A read of 0x060 + 4*b returns the levels of bank b's `pin_in` bits after a two-flop synchronizer. A level applied before clock edge n is returned by a read captured at edge n+2 and by no earlier read.
- R6: The direction word of bank b is readable and writable at 0x204 + 0x40*b. Bit value 1 means output.
- R7: The output-enable word of bank b is readable and writable at 0x208 + 0x40*b. A `pin_oe` bit is 1 only when both the direction bit and the output-enable bit of that pin are 1.
- R8: Bit positions at or above a bank's pin count read 0 from every register, never drive `pin_out` or `pin_oe`, and ignore their `pin_in` levels.
- R9: In bank 0, direction bits 7 and 8 stay 1 once set. A later write of 0 to either bit is ignored, while the other bits of that write take effect.
- R10: Reads of the mask/data addresses, and of any address that decodes to no register, return 0.
- R11: A write to one bank leaves the outputs and registers of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| pin_in | input | NUM_BANKS*32 | Pin levels, 32 bits per bank, bank 0 lowest |
| pin_out | output | NUM_BANKS*32 | Output level per pin |
| pin_oe | output | NUM_BANKS*32 | Pad driver enable per pin |

## Verification
Masked writes use three patterns. An all-clear mask shows that data lands on the correct half of the correct bank. A split mask, with one byte protected and one open, separates keep from update within a single word. A write to the upper half then confirms that the lower half is left alone. The narrow bank receives all-ones data and all-ones direction writes, which exposes any storage or drive above its pin count. A level change is read on three back-to-back cycles, which pins the synchronizer depth to exactly two flops. The lock test writes 0x181 and then 0, so a lock that blocks too much and a lock that blocks nothing give different read-back values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_MD_LO,
    RK_MD_HI,
    RK_LEVEL,
    RK_DIR,
    RK_OE
  } reg_kind_e;

  function automatic logic [WORD_W-1:0] valid_mask(input int unsigned pins);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      if (i < pins) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned BANK_IW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  output reg_kind_e          kind,
  output logic [BANK_IW-1:0] bank
);
  always_comb begin
    kind = RK_NONE;
    bank = '0;
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(8 * b)) begin
        kind = RK_MD_LO; bank = BANK_IW'(b);
      end else if (addr == ADDR_W'(8 * b + 4)) begin
        kind = RK_MD_HI; bank = BANK_IW'(b);
      end else if (addr == ADDR_W'(32'h060 + 4 * b)) begin
        kind = RK_LEVEL; bank = BANK_IW'(b);
      end else if (addr == ADDR_W'(32'h204 + 32'h40 * b)) begin
        kind = RK_DIR; bank = BANK_IW'(b);
      end else if (addr == ADDR_W'(32'h208 + 32'h40 * b)) begin
        kind = RK_OE; bank = BANK_IW'(b);
      end
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned     PINS      = 32,
  parameter logic [31:0]     LOCK_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_dir,
  input  logic              wr_oe,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] out_q,
  output logic [WORD_W-1:0] dir_q,
  output logic [WORD_W-1:0] oe_q
);
  localparam logic [WORD_W-1:0] VALID = valid_mask(PINS);

  logic [HALF_W-1:0] keep, newd;
  logic [WORD_W-1:0] out_d;

  assign keep = wdata[WORD_W-1:HALF_W];
  assign newd = wdata[HALF_W-1:0];

  always_comb begin
    out_d = out_q;
    if (wr_lo) out_d[HALF_W-1:0]      = (out_q[HALF_W-1:0] & keep) | (newd & ~keep);
    if (wr_hi) out_d[WORD_W-1:HALF_W] = (out_q[WORD_W-1:HALF_W] & keep) | (newd & ~keep);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= out_d & VALID;
      if (wr_dir) dir_q <= (wdata | (dir_q & LOCK_MASK)) & VALID;
      if (wr_oe)  oe_q  <= wdata & VALID;
    end
  end

  AST_MASK_HOLD_LO: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (((out_q[HALF_W-1:0] ^ $past(out_q[HALF_W-1:0])) & $past(wdata[WORD_W-1:HALF_W])) == '0)); // R3
  AST_MASK_HOLD_HI: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (((out_q[WORD_W-1:HALF_W] ^ $past(out_q[WORD_W-1:HALF_W])) & $past(wdata[WORD_W-1:HALF_W])) == '0)); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_lo || wr_hi || wr_dir || wr_oe) |=> ($stable(out_q) && $stable(dir_q) && $stable(oe_q))); // R11

  generate
    if (LOCK_MASK != '0) begin : g_lock_chk
      AST_DIR_LOCK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((LOCK_MASK & VALID & $past(dir_q) & ~dir_q) == '0)); // R9
    end
  endgenerate
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [NUM_BANKS*8-1:0] BANK_PINS = {8'd32, 8'd32, 8'd22, 8'd32},
  parameter logic [31:0] BANK0_LOCK = 32'h0000_0180
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_BANKS*WORD_W-1:0] pin_in,
  output logic [NUM_BANKS*WORD_W-1:0] pin_out,
  output logic [NUM_BANKS*WORD_W-1:0] pin_oe
);
  localparam int unsigned BANK_IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  reg_kind_e                      kind;
  logic [BANK_IW-1:0]             bank;
  logic [NUM_BANKS*WORD_W-1:0]    level;
  logic [NUM_BANKS-1:0][WORD_W-1:0] out_a, dir_a, oe_a, valid_a;
  logic [WORD_W-1:0]              rd_val;

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .kind(kind), .bank(bank)
  );

  gpio_sync #(.W(NUM_BANKS*WORD_W)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(level)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned PINS = int'(BANK_PINS[b*8 +: 8]);
      localparam logic [31:0] LOCK = (b == 0) ? BANK0_LOCK : 32'h0;
      logic sel;
      assign sel = bus_wr && (bank == BANK_IW'(b));

      gpio_bank #(.PINS(PINS), .LOCK_MASK(LOCK)) u_bank (
        .clk(clk), .rst(rst),
        .wr_lo (sel && kind == RK_MD_LO),
        .wr_hi (sel && kind == RK_MD_HI),
        .wr_dir(sel && kind == RK_DIR),
        .wr_oe (sel && kind == RK_OE),
        .wdata(bus_wdata),
        .out_q(out_a[b]), .dir_q(dir_a[b]), .oe_q(oe_a[b])
      );

      assign valid_a[b]               = valid_mask(PINS);
      assign pin_out[b*WORD_W +: WORD_W] = out_a[b];
      assign pin_oe[b*WORD_W +: WORD_W]  = dir_a[b] & oe_a[b];
    end
  endgenerate

  always_comb begin
    case (kind)
      RK_LEVEL: rd_val = level[bank*WORD_W +: WORD_W] & valid_a[bank];
      RK_DIR:   rd_val = dir_a[bank];
      RK_OE:    rd_val = oe_a[bank];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_val : '0;
  end

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (kind == RK_MD_LO || kind == RK_MD_HI || kind == RK_NONE)) |=> (bus_rdata == '0)); // R10
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
  localparam int NB = 4;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NB*32-1:0] pin_in = '0;
  logic [NB*32-1:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [31:0] exp; } exp_t;
  exp_t sb[$];
  logic rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.tag = tag; e.exp = exp;
    sb.push_back(e);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compares registered read data against the scoreboard
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read data %08h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, bus_rdata, e.exp);
      end
    end
  end

  function automatic logic [31:0] pw(input logic [NB*32-1:0] v, input int b);
    return v[b*32 +: 32];
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_out bank0", pw(pin_out, 0), 32'h0);
    chk("R1 pin_oe bank3", pw(pin_oe, 3), 32'h0);
    do_read(12'h204, 32'h0, "R1 dir bank0 after reset");
    do_read(12'h288, 32'h0, "R1 oe bank2 after reset");

    // R2 low-half write, open mask
    do_write(12'h000, 32'h0000_A5A5);
    chk("R2 low half bank0", pw(pin_out, 0), 32'h0000_A5A5);
    // R3 upper byte protected
    do_write(12'h000, 32'hFF00_0000);
    chk("R3 masked keep bank0", pw(pin_out, 0), 32'h0000_A500);
    // R4 high half
    do_write(12'h004, 32'h0000_1234);
    chk("R4 high half bank0", pw(pin_out, 0), 32'h1234_A500);
    // R3 on high half: keep bits 31:24 (mask bits 15:8)
    do_write(12'h004, 32'hFF00_FFFF);
    chk("R3 high half keep", pw(pin_out, 0), 32'h12FF_A500);

    // R8 narrow bank (22 pins) and R11 isolation
    do_write(12'h00C, 32'h0000_FFFF);
    chk("R8 bank1 high bits", pw(pin_out, 1), 32'h003F_0000);
    chk("R11 bank0 untouched", pw(pin_out, 0), 32'h12FF_A500);
    chk("R11 bank2 untouched", pw(pin_out, 2), 32'h0);

    // R6 and R7
    do_write(12'h284, 32'hFFFF_0000);
    do_read(12'h284, 32'hFFFF_0000, "R6 dir bank2 readback");
    chk("R7 oe off while only dir set", pw(pin_oe, 2), 32'h0);
    do_write(12'h288, 32'h00FF_00FF);
    chk("R7 pin_oe bank2 dir&oe", pw(pin_oe, 2), 32'h00FF_0000);
    do_read(12'h288, 32'h00FF_00FF, "R7 oe bank2 readback");

    // R8 narrow bank direction
    do_write(12'h244, 32'hFFFF_FFFF);
    do_read(12'h244, 32'h003F_FFFF, "R8 dir bank1 readback");
    do_write(12'h248, 32'hFFFF_FFFF);
    chk("R8 pin_oe bank1", pw(pin_oe, 1), 32'h003F_FFFF);

    // R9 direction lock in bank 0
    do_write(12'h204, 32'h0000_0181);
    do_write(12'h204, 32'h0000_0000);
    do_read(12'h204, 32'h0000_0180, "R9 locked dir bits");
    do_write(12'h2C4, 32'h0000_0180);
    do_write(12'h2C4, 32'h0000_0000);
    do_read(12'h2C4, 32'h0000_0000, "R9 no lock on bank3");

    // R5 synchronizer depth
    pin_in[31:0] = 32'h0000_0005;
    do_read(12'h060, 32'h0, "R5 level one edge");
    do_read(12'h060, 32'h0, "R5 level two edges pre");
    do_read(12'h060, 32'h0000_0005, "R5 level after two flops");
    pin_in[127:96] = 32'hDEAD_BEEF;
    pin_in[63:32]  = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    do_read(12'h06C, 32'hDEAD_BEEF, "R5 level bank3");
    do_read(12'h064, 32'h003F_FFFF, "R8 level bank1 narrow");

    // R10 write-only and unmapped reads
    do_read(12'h000, 32'h0, "R10 read low mask/data");
    do_read(12'h01C, 32'h0, "R10 read high mask/data bank3");
    do_read(12'h100, 32'h0, "R10 read unmapped");
    chk("R10 pins unchanged by reads", pw(pin_out, 0), 32'h12FF_A500);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", sb.size(), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule